// File: doc/BRIEF.md
# Page-Boundary Transaction Splitter

This block sits between a memory request queue and the command sequencer of an SDRAM controller. Each incoming transaction gives a start address, a byte count and a direction. The block cuts the transaction into segments so that no segment reaches across an SDRAM page. A read yields one completion per segment, and every segment except the final one stops exactly at a page edge. A write goes into a posted buffer that holds at most 32 bytes. One write command is issued for each page that the buffered range touches.

Both sides use a valid/ready handshake. The block holds one transaction at a time. It does not take the next transaction until the last segment of the current one has been handed downstream. A request with a byte count of zero, or a write larger than the posted buffer, is refused: the block raises a one-cycle error pulse and issues no segments for it. The page size is a power-of-two parameter.

Top module: `page_splitter`

## Requirements
- R1: After a synchronous active-low reset, `in_ready` is 1 and both `seg_valid` and `err_valid` are 0.
- R2: No issued segment crosses a page: the first and last byte of every segment have the same page index (address divided by `PAGE_BYTES`).
- R3: The first segment of a transaction starts at its start address. Each later segment starts at the byte after the one before it. The segment lengths add up to the byte count.
- R4: Every segment that is not the last one of its transaction ends exactly at a page boundary, so that address plus length is a multiple of `PAGE_BYTES`.
- R5: `seg_last` is 1 on the final segment of a transaction and 0 on every other segment.
- R6: A request with a byte count of 0, read or write, is accepted. It produces `err_valid` = 1 in the next cycle and no segments.
- R7: A write (`in_write` = 1) of more than `WBUF_BYTES` (32) bytes is accepted and answered with `err_valid` in the next cycle and no segments. A write of 1 to 32 bytes is processed normally.
- R8: A posted write is issued as exactly one segment per page it touches, and every such segment carries `seg_write` = 1. Segments of a read carry `seg_write` = 0.
- R9: `in_ready` is 0 from the cycle after a valid transaction is accepted until the cycle after its last segment handshake. No new transaction is taken in between.
- R10: While `seg_valid` is 1 and `seg_ready` is 0, the segment fields hold their values and `seg_valid` stays 1.
- R11: The first segment appears on `seg_valid` in the cycle right after a valid transaction is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Transaction request present |
| in_ready | output | 1 | Block can take a transaction |
| in_addr | input | ADDR_W | Start byte address |
| in_len | input | LEN_W | Byte count |
| in_write | input | 1 | 1 = posted write, 0 = read |
| err_valid | output | 1 | One-cycle pulse: last accepted request was refused |
| seg_valid | output | 1 | Segment available |
| seg_ready | input | 1 | Sequencer takes the segment |
| seg_addr | output | ADDR_W | Segment start address |
| seg_len | output | LEN_W | Segment byte count |
| seg_write | output | 1 | Segment direction |
| seg_last | output | 1 | Final segment of the transaction |

## Verification
The collision that matters is the final segment handshake falling in the same cycle as a new request waiting at the input. The bench keeps `in_valid` high with the next transaction queued behind the current one, and it throttles `seg_ready` with a pseudo-random pattern so the last handshake lands in many different cycles. The reference model requires the waiting request to be refused in the handshake cycle and taken in the next one. It also requires a refused request to produce its error pulse without disturbing the idle state that follows.

// File: rtl/ps_pkg.sv
package ps_pkg;
   typedef enum logic [0:0] {
      PS_IDLE  = 1'b0,
      PS_ISSUE = 1'b1
   } ps_state_e;
endpackage

// File: rtl/ps_req_check.sv
module ps_req_check #(
   parameter int LEN_W      = 12,
   parameter int WBUF_BYTES = 32,
   parameter bit WLIMIT_EN  = 1'b1
) (
   input  logic [LEN_W-1:0] len,
   input  logic             is_write,
   output logic             bad
);
   localparam int LW = (LEN_W > 32) ? LEN_W : 32;

   logic zero_len;
   logic too_big;

   assign zero_len = (len == '0);

   generate
      if (WLIMIT_EN) begin : g_wlimit
         assign too_big = is_write && (LW'(len) > LW'(WBUF_BYTES));
      end else begin : g_nolimit
         assign too_big = 1'b0;
      end
   endgenerate

   assign bad = zero_len || too_big;
endmodule

// File: rtl/ps_seg_calc.sv
module ps_seg_calc #(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 12,
   parameter int PAGE_BYTES = 2048
) (
   input  logic [ADDR_W-1:0] cur_addr,
   input  logic [LEN_W-1:0]  remain,
   output logic [LEN_W-1:0]  seg_len,
   output logic              fits
);
   localparam int PAGE_W = $clog2(PAGE_BYTES);
   localparam int CW     = (LEN_W > PAGE_W + 1) ? LEN_W : PAGE_W + 1;

   logic [CW-1:0] room;
   logic [CW-1:0] rem_x;

   assign room  = CW'(PAGE_BYTES) - CW'(cur_addr[PAGE_W-1:0]);
   assign rem_x = CW'(remain);
   assign fits  = (rem_x <= room);
   assign seg_len = fits ? remain : LEN_W'(room);
endmodule

// File: rtl/page_splitter.sv
module page_splitter #(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 12,
   parameter int PAGE_BYTES = 2048,
   parameter int WBUF_BYTES = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic [LEN_W-1:0]  in_len,
   input  logic              in_write,
   output logic              err_valid,
   output logic              seg_valid,
   input  logic              seg_ready,
   output logic [ADDR_W-1:0] seg_addr,
   output logic [LEN_W-1:0]  seg_len,
   output logic              seg_write,
   output logic              seg_last
);
   import ps_pkg::*;

   localparam int PAGE_W = $clog2(PAGE_BYTES);

   generate
      if (PAGE_W < 1 || (1 << PAGE_W) != PAGE_BYTES) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two of at least 2");
      end
      if (PAGE_W >= ADDR_W) begin : g_bad_addr
         $error("ADDR_W must exceed the page offset width");
      end
      if (LEN_W < 1 || WBUF_BYTES < 1 || WBUF_BYTES >= (1 << LEN_W)) begin : g_bad_len
         $error("WBUF_BYTES must be representable in LEN_W bits");
      end
   endgenerate

   ps_state_e         state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  remain_q;
   logic              write_q;
   logic              err_q;

   logic              req_bad;
   logic [LEN_W-1:0]  cut_len;
   logic              cut_fits;
   logic              take_req;
   logic              seg_fire;

   ps_req_check #(
      .LEN_W      (LEN_W),
      .WBUF_BYTES (WBUF_BYTES),
      .WLIMIT_EN  (1'b1)
   ) u_req_check (
      .len      (in_len),
      .is_write (in_write),
      .bad      (req_bad)
   );

   ps_seg_calc #(
      .ADDR_W     (ADDR_W),
      .LEN_W      (LEN_W),
      .PAGE_BYTES (PAGE_BYTES)
   ) u_seg_calc (
      .cur_addr (addr_q),
      .remain   (remain_q),
      .seg_len  (cut_len),
      .fits     (cut_fits)
   );

   assign in_ready  = (state_q == PS_IDLE);
   assign take_req  = in_valid && in_ready;
   assign seg_valid = (state_q == PS_ISSUE);
   assign seg_fire  = seg_valid && seg_ready;

   assign seg_addr  = addr_q;
   assign seg_len   = cut_len;
   assign seg_write = write_q;
   assign seg_last  = cut_fits;
   assign err_valid = err_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= PS_IDLE;
         addr_q   <= '0;
         remain_q <= '0;
         write_q  <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         err_q <= take_req && req_bad;
         case (state_q)
            PS_IDLE: begin
               if (take_req && !req_bad) begin
                  addr_q   <= in_addr;
                  remain_q <= in_len;
                  write_q  <= in_write;
                  state_q  <= PS_ISSUE;
               end
            end
            PS_ISSUE: begin
               if (seg_fire) begin
                  addr_q   <= addr_q + ADDR_W'(cut_len);
                  remain_q <= remain_q - cut_len;
                  if (cut_fits) begin
                     state_q <= PS_IDLE;
                  end
               end
            end
            default: state_q <= PS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/page_splitter_chk.sv
module page_splitter_chk #(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 12,
   parameter int PAGE_BYTES = 2048,
   parameter int WBUF_BYTES = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [ADDR_W-1:0] in_addr,
   input logic [LEN_W-1:0]  in_len,
   input logic              in_write,
   input logic              err_valid,
   input logic              seg_valid,
   input logic              seg_ready,
   input logic [ADDR_W-1:0] seg_addr,
   input logic [LEN_W-1:0]  seg_len,
   input logic              seg_write,
   input logic              seg_last
);
   localparam int PAGE_W = $clog2(PAGE_BYTES);

   logic [ADDR_W-1:0] end_excl;
   logic [ADDR_W-1:0] end_incl;
   logic              good_req;

   always_comb begin
      end_excl = seg_addr + ADDR_W'(seg_len);
      end_incl = end_excl - ADDR_W'(1);
      good_req = (in_len != '0) &&
                 !(in_write && (32'(in_len) > 32'(WBUF_BYTES)));
   end

   assert_in_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid |-> (seg_len != '0) &&
                    (seg_addr[ADDR_W-1:PAGE_W] == end_incl[ADDR_W-1:PAGE_W]));

   assert_contig_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_valid && seg_ready && !seg_last) |=>
         (seg_valid && seg_addr == $past(end_excl)));

   assert_edge_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_valid && !seg_last) |-> (end_excl[PAGE_W-1:0] == '0));

   assert_err_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |-> ($past(in_valid && in_ready) && !seg_valid));

   assert_wbuf_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_valid && seg_write) |-> (32'(seg_len) <= 32'(WBUF_BYTES)));

   assert_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      seg_valid |-> !in_ready);

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_valid && !seg_ready) |=>
         (seg_valid && $stable(seg_addr) && $stable(seg_len) &&
          $stable(seg_write) && $stable(seg_last)));

   assert_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && good_req) |=> (seg_valid && seg_addr == $past(in_addr)));
endmodule

bind page_splitter page_splitter_chk #(
   .ADDR_W     (ADDR_W),
   .LEN_W      (LEN_W),
   .PAGE_BYTES (PAGE_BYTES),
   .WBUF_BYTES (WBUF_BYTES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_addr   (in_addr),
   .in_len    (in_len),
   .in_write  (in_write),
   .err_valid (err_valid),
   .seg_valid (seg_valid),
   .seg_ready (seg_ready),
   .seg_addr  (seg_addr),
   .seg_len   (seg_len),
   .seg_write (seg_write),
   .seg_last  (seg_last)
);

// File: tb/page_splitter_bench.sv
module page_splitter_bench;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 32;
   localparam int LEN_W      = 12;
   localparam int PAGE       = 64;
   localparam int WBUF       = 32;
   localparam int LIMIT      = 20000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [ADDR_W-1:0] in_addr = '0;
   logic [LEN_W-1:0]  in_len = '0;
   logic              in_write = 1'b0;
   logic              err_valid;
   logic              seg_valid;
   logic              seg_ready = 1'b0;
   logic [ADDR_W-1:0] seg_addr;
   logic [LEN_W-1:0]  seg_len;
   logic              seg_write;
   logic              seg_last;

   always #(CLK_PERIOD/2) clk = ~clk;

   page_splitter #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE), .WBUF_BYTES(WBUF)
   ) u_page_splitter (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
      .in_len(in_len), .in_write(in_write), .err_valid(err_valid),
      .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
      .seg_len(seg_len), .seg_write(seg_write), .seg_last(seg_last)
   );

   typedef struct {
      int unsigned addr;
      int unsigned len;
      bit          wr;
   } txn_t;

   typedef struct {
      int unsigned addr;
      int unsigned len;
      bit          wr;
      bit          last;
   } seg_t;

   txn_t pend[$];
   seg_t m_q[$];
   bit   m_busy = 0;
   bit   m_err  = 0;
   int   n_chk  = 0;
   int   n_bad  = 0;
   int   phase  = 0;

   task automatic chk(input bit ok, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", what, act, exp, $time);
      end
   endtask

   task automatic add(input int unsigned a, input int unsigned l, input bit w);
      txn_t t;
      t.addr = a; t.len = l; t.wr = w;
      pend.push_back(t);
   endtask

   task automatic compare();
      chk(in_ready == !m_busy, "R9 in_ready", int'(in_ready), int'(!m_busy));
      chk(seg_valid == m_busy, "R11 seg_valid", int'(seg_valid), int'(m_busy));
      chk(err_valid == m_err, "R6 R7 err_valid", int'(err_valid), int'(m_err));
      if (m_busy && seg_valid) begin
         chk(seg_addr == m_q[0].addr, "R3 R10 seg_addr", int'(seg_addr), int'(m_q[0].addr));
         chk(32'(seg_len) == m_q[0].len, "R2 R3 seg_len", int'(seg_len), int'(m_q[0].len));
         chk(seg_write == m_q[0].wr, "R8 seg_write", int'(seg_write), int'(m_q[0].wr));
         chk(seg_last == m_q[0].last, "R5 seg_last", int'(seg_last), int'(m_q[0].last));
         if (!seg_last)
            chk(((seg_addr + 32'(seg_len)) % PAGE) == 0, "R4 page end",
                int'((seg_addr + 32'(seg_len)) % PAGE), 0);
      end
   endtask

   task automatic model_step();
      m_err = 0;
      if (m_busy) begin
         if (seg_ready) begin
            void'(m_q.pop_front());
            if (m_q.size() == 0) m_busy = 0;
         end
      end else if (in_valid) begin
         txn_t t;
         t = pend.pop_front();
         if (t.len == 0 || (t.wr && t.len > WBUF)) begin
            m_err = 1;
         end else begin
            int unsigned a = t.addr;
            int unsigned r = t.len;
            while (r > 0) begin
               seg_t s;
               int unsigned room = PAGE - (a % PAGE);
               s.addr = a;
               s.len  = (r < room) ? r : room;
               s.wr   = t.wr;
               a = a + s.len;
               r = r - s.len;
               s.last = (r == 0);
               m_q.push_back(s);
            end
            m_busy = 1;
         end
      end
   endtask

   initial begin
      int cyc = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
      chk(seg_valid == 1'b0, "R1 seg_valid", int'(seg_valid), 0);
      chk(err_valid == 1'b0, "R1 err_valid", int'(err_valid), 0);

      // reads
      add(0, 16, 0);      // inside one page
      add(60, 200, 0);    // crosses several pages
      add(64, 64, 0);     // exactly one full page
      add(32, 32, 0);     // ends on boundary
      add(0, 128, 0);     // two full pages
      add(5, 0, 0);       // R6 zero read
      add(7, 0, 1);       // R6 zero write
      // writes
      add(48, 32, 1);     // R8 spans two pages
      add(100, 33, 1);    // R7 too big
      add(128, 32, 1);    // R7 full buffer, one page
      add(63, 1, 1);      // single byte at page end
      add(62, 4, 1);      // R8 two pages
      add(200, 300, 0);
      add(10, 0, 0);
      add(1, 3000, 0);    // long read

      while ((pend.size() > 0 || m_busy || m_err) && cyc < LIMIT) begin
         compare();
         if (pend.size() > 0) begin
            in_valid = 1'b1;
            in_addr  = ADDR_W'(pend[0].addr);
            in_len   = LEN_W'(pend[0].len);
            in_write = pend[0].wr;
         end else begin
            in_valid = 1'b0;
         end
         phase = (cyc / 150) % 3;
         if (phase == 0) seg_ready = 1'b1;
         else if (phase == 1) seg_ready = ($urandom_range(0, 3) != 0);
         else seg_ready = ($urandom_range(0, 1) != 0);
         model_step();
         cyc++;
         @(negedge clk);
      end
      if (cyc >= LIMIT) chk(1'b0, "watchdog", cyc, LIMIT);
      in_valid = 1'b0;
      compare();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule